// File: doc/BRIEF.md
# Slow-Clock Counter with Compare Interrupt

This block is a free-running counter that lives in a slow timekeeping clock domain (nominally 32.768 kHz) and is programmed over a simple register port clocked by the fast system clock. Software can read the current count, preload it, set a prescale (trim) divider and arm a compare value. When the counter steps onto the compare value, a sticky interrupt is raised. Software uses this to schedule one-shot events: read the count, add a delta of at least about nine ticks, and write the sum as the compare value.

Each write that targets the slow domain is posted. The value is held on the fast side and carried across with a toggle request and a returning toggle acknowledge. While that round trip is in flight, a busy bit for that register is visible in the control word. A further write to the same register during that window is dropped. The count is read through a snapshot that a handshake keeps refreshed, so a read always returns one coherent value. A sticky status bit shows that the slow clock has produced at least one edge.

Register map, with word addresses on `wr_addr`/`rd_addr`:
- 0, control: bit0 enable (read/write); bit1 slow clock seen; bit2 trim busy; bit3 count busy; bit4 compare busy.
- 1, count: read gives the snapshot; write gives the preload.
- 2, trim.
- 3, compare.
- 4, interrupt: bit0 pending; writing 1 clears it.

Top module: `lfc_timer`

## Requirements
- R1: The count is CNT_W (32) bits wide and wraps modulo 2^CNT_W. From 0xFFFFFFFE it passes through 0 and keeps counting. It never advances by more than one per slow clock edge.
- R2: With trim value N written at address 2, the enabled counter advances once every N+1 slow edges. N = 0 advances on every slow edge.
- R3: A write to address 2 sets control bit2 from the next fast cycle until the slow domain has acknowledged the value. A write to address 2 while bit2 is set is ignored. Reading address 2 returns the last accepted trim value.
- R4: A write to address 1 loads the counter and restarts the prescaler. Control bit3 is set while that load is pending. After the load, a read of address 1 returns the loaded value.
- R5: A write to address 3 sets control bit4 until it is acknowledged. A write to address 3 while bit4 is set is ignored. Reading address 3 returns the accepted compare value.
- R6: When the counter advances onto the compare value, interrupt bit0 (address 4) and the `irq` pin go high and stay high. They fall only when 1 is written to bit0 of address 4. A compare value that the counter does not step onto raises nothing.
- R7: Control bit1 goes to 1 after the slow clock has run and stays 1.
- R8: Control bit0 enables counting. While it is 0, the count holds its value.
- R9: A read of address 1 returns one coherent sampled count. It equals the exact value of a stopped counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast register-port clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| slow_clk | input | 1 | Slow timekeeping clock |
| wr_en | input | 1 | Write strobe, one fast cycle per write |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Compare interrupt level |

## Verification
The hardest case to reach is a second write that arrives while the first is still crossing. The stimulus issues two writes to trim or compare on back-to-back fast cycles and later reads the register back. The ignored write is also shown to have no effect through the counting rate and through where the interrupt fires. The counter rate is measured as exact ranges rather than single values. This is done by preloading a stopped counter, enabling it for a known number of slow edges and stopping it again. Both enable edges see the same synchroniser delay, so a read after the stop is exact.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 3'd0,
      A_COUNT = 3'd1,
      A_TRIM  = 3'd2,
      A_MATCH = 3'd3,
      A_IRQ   = 3'd4
   } lfc_addr_e;

   // control word bit positions
   localparam int B_EN      = 0;
   localparam int B_PRESENT = 1;
   localparam int B_TRIMBSY = 2;
   localparam int B_LOADBSY = 3;
   localparam int B_MATCHBSY = 4;
endpackage

// File: rtl/lfc_sync.sv
module lfc_sync #(
   parameter int W = 1,
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [N-1:0][W-1:0] st;

   generate
      if (N == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= '0;
            else        st <= d;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st <= '0;
            else        st <= {st[N-2:0], d};
      end
   endgenerate

   assign q = st[N-1];
endmodule

// File: rtl/lfc_wxfer.sv
// Posted write crossing: fast-side holding register and request toggle,
// slow-side capture with strobe, acknowledge toggle back to the fast side.
module lfc_wxfer #(
   parameter int W = 32,
   parameter int N = 2
) (
   input  logic         fclk,
   input  logic         frst_n,
   input  logic         start,
   input  logic [W-1:0] din,
   output logic         busy,
   output logic [W-1:0] hold,
   input  logic         sclk,
   input  logic         srst_n,
   output logic [W-1:0] dout,
   output logic         dstb
);
   logic req_t, ack_f, req_s, req_d;

   always_ff @(posedge fclk or negedge frst_n)
      if (!frst_n) begin
         hold  <= '0;
         req_t <= 1'b0;
      end else if (start && !busy) begin
         hold  <= din;
         req_t <= ~req_t;
      end

   lfc_sync #(.W(1), .N(N)) u_req (.clk(sclk), .rst_n(srst_n), .d(req_t), .q(req_s));

   always_ff @(posedge sclk or negedge srst_n)
      if (!srst_n) begin
         req_d <= 1'b0;
         dout  <= '0;
         dstb  <= 1'b0;
      end else begin
         req_d <= req_s;
         dstb  <= req_s ^ req_d;
         if (req_s ^ req_d) dout <= hold;
      end

   // req_d is the acknowledge toggle: it flips in the same edge as the capture
   lfc_sync #(.W(1), .N(N)) u_ack (.clk(fclk), .rst_n(frst_n), .d(req_d), .q(ack_f));

   assign busy = req_t ^ ack_f;
endmodule

// File: rtl/lfc_core.sv
// Slow-domain prescaler, counter and compare.
module lfc_core #(
   parameter int CNT_W  = 32,
   parameter int TRIM_W = 16
) (
   input  logic              sclk,
   input  logic              srst_n,
   input  logic              en,
   input  logic              trim_stb,
   input  logic [TRIM_W-1:0] trim_v,
   input  logic              load_stb,
   input  logic [CNT_W-1:0]  load_v,
   input  logic              match_stb,
   input  logic [CNT_W-1:0]  match_v,
   output logic [CNT_W-1:0]  cnt,
   output logic              evt_t,
   output logic              alive
);
   logic [TRIM_W-1:0] pre, trim_r;
   logic [CNT_W-1:0]  match_r;
   logic [CNT_W-1:0]  nxt;

   assign nxt = cnt + 1'b1;

   always_ff @(posedge sclk or negedge srst_n)
      if (!srst_n) begin
         trim_r  <= '0;
         match_r <= '0;
      end else begin
         if (trim_stb)  trim_r  <= trim_v;
         if (match_stb) match_r <= match_v;
      end

   always_ff @(posedge sclk or negedge srst_n)
      if (!srst_n) begin
         pre   <= '0;
         cnt   <= '0;
         evt_t <= 1'b0;
         alive <= 1'b0;
      end else begin
         alive <= 1'b1;
         if (load_stb) begin
            cnt <= load_v;
            pre <= '0;
         end else if (trim_stb) begin
            pre <= '0;
         end else if (en) begin
            if (pre >= trim_r) begin
               pre <= '0;
               cnt <= nxt;
               if (nxt == match_r) evt_t <= ~evt_t;
            end else begin
               pre <= pre + 1'b1;
            end
         end
      end
endmodule

// File: rtl/lfc_timer.sv
module lfc_timer
   import lfc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int TRIM_W = 16,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              irq
);
   initial begin
      assert (SYNC_N >= 2) else $error("SYNC_N must be at least 2");
      assert (TRIM_W >= 1 && TRIM_W <= CNT_W) else $error("TRIM_W out of range");
      assert (CNT_W >= 8) else $error("CNT_W too small for the control word");
   end

   logic wr_trim, wr_load, wr_match, wr_ctrl, clr;
   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign wr_load  = wr_en && (wr_addr == A_COUNT);
   assign wr_trim  = wr_en && (wr_addr == A_TRIM);
   assign wr_match = wr_en && (wr_addr == A_MATCH);
   assign clr      = wr_en && (wr_addr == A_IRQ) && wr_data[0];

   // ---------------- write crossings ----------------
   logic              trim_busy, load_busy, match_busy;
   logic [TRIM_W-1:0] trim_hold, trim_s;
   logic [CNT_W-1:0]  load_hold, load_s, match_hold, match_s;
   logic              trim_stb, load_stb, match_stb;

   lfc_wxfer #(.W(TRIM_W), .N(SYNC_N)) u_trim (
      .fclk(clk), .frst_n(rst_n), .start(wr_trim), .din(wr_data[TRIM_W-1:0]),
      .busy(trim_busy), .hold(trim_hold),
      .sclk(slow_clk), .srst_n(rst_n), .dout(trim_s), .dstb(trim_stb));

   lfc_wxfer #(.W(CNT_W), .N(SYNC_N)) u_load (
      .fclk(clk), .frst_n(rst_n), .start(wr_load), .din(wr_data),
      .busy(load_busy), .hold(load_hold),
      .sclk(slow_clk), .srst_n(rst_n), .dout(load_s), .dstb(load_stb));

   lfc_wxfer #(.W(CNT_W), .N(SYNC_N)) u_match (
      .fclk(clk), .frst_n(rst_n), .start(wr_match), .din(wr_data),
      .busy(match_busy), .hold(match_hold),
      .sclk(slow_clk), .srst_n(rst_n), .dout(match_s), .dstb(match_stb));

   // ---------------- enable level ----------------
   logic en_q, en_s;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       en_q <= 1'b0;
      else if (wr_ctrl) en_q <= wr_data[B_EN];

   lfc_sync #(.W(1), .N(SYNC_N)) u_en (.clk(slow_clk), .rst_n(rst_n), .d(en_q), .q(en_s));

   // ---------------- slow core ----------------
   logic [CNT_W-1:0] cnt;
   logic             evt_t, alive;

   lfc_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_core (
      .sclk(slow_clk), .srst_n(rst_n), .en(en_s),
      .trim_stb(trim_stb), .trim_v(trim_s),
      .load_stb(load_stb), .load_v(load_s),
      .match_stb(match_stb), .match_v(match_s),
      .cnt(cnt), .evt_t(evt_t), .alive(alive));

   // ---------------- count snapshot loop ----------------
   logic             snap_req, snap_req_s, snap_req_d, snap_ack_f;
   logic [CNT_W-1:0] snap_s, cnt_f;

   lfc_sync #(.W(1), .N(SYNC_N)) u_sreq (.clk(slow_clk), .rst_n(rst_n), .d(snap_req), .q(snap_req_s));

   always_ff @(posedge slow_clk or negedge rst_n)
      if (!rst_n) begin
         snap_req_d <= 1'b0;
         snap_s     <= '0;
      end else begin
         snap_req_d <= snap_req_s;
         if (snap_req_s ^ snap_req_d) snap_s <= cnt;
      end

   lfc_sync #(.W(1), .N(SYNC_N)) u_sack (.clk(clk), .rst_n(rst_n), .d(snap_req_d), .q(snap_ack_f));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         snap_req <= 1'b0;
         cnt_f    <= '0;
      end else if (snap_ack_f == snap_req) begin
         cnt_f    <= snap_s;
         snap_req <= ~snap_req;
      end

   // ---------------- event, interrupt, presence ----------------
   logic evt_sync, evt_d, evt_f, irq_q, alive_f, present;

   lfc_sync #(.W(1), .N(SYNC_N)) u_evt (.clk(clk), .rst_n(rst_n), .d(evt_t), .q(evt_sync));
   lfc_sync #(.W(1), .N(SYNC_N)) u_alv (.clk(clk), .rst_n(rst_n), .d(alive), .q(alive_f));

   assign evt_f = evt_sync ^ evt_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         evt_d   <= 1'b0;
         irq_q   <= 1'b0;
         present <= 1'b0;
      end else begin
         evt_d <= evt_sync;
         if (evt_f)    irq_q <= 1'b1;
         else if (clr) irq_q <= 1'b0;
         if (alive_f)  present <= 1'b1;
      end

   assign irq = irq_q;

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL: begin
            rd_data[B_EN]       = en_q;
            rd_data[B_PRESENT]  = present;
            rd_data[B_TRIMBSY]  = trim_busy;
            rd_data[B_LOADBSY]  = load_busy;
            rd_data[B_MATCHBSY] = match_busy;
         end
         A_COUNT: rd_data = cnt_f;
         A_TRIM:  rd_data[TRIM_W-1:0] = trim_hold;
         A_MATCH: rd_data = match_hold;
         A_IRQ:   rd_data[0] = irq_q;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/lfc_timer_chk.sv
module lfc_timer_chk #(
   parameter int CNT_W  = 32,
   parameter int TRIM_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slow_clk,
   input logic              wr_trim,
   input logic              wr_load,
   input logic              wr_match,
   input logic              trim_busy,
   input logic              load_busy,
   input logic              match_busy,
   input logic [TRIM_W-1:0] trim_hold,
   input logic [CNT_W-1:0]  match_hold,
   input logic              load_stb,
   input logic              en_s,
   input logic [CNT_W-1:0]  cnt,
   input logic              clr,
   input logic              evt_f,
   input logic              irq,
   input logic              present
);
   // R1: at most one step per slow edge unless a load lands
   p_single_step_r1: assert property (@(posedge slow_clk) disable iff (!rst_n)
      !load_stb |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

   p_trim_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_trim && !trim_busy) |=> trim_busy);

   p_trim_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_trim && trim_busy) |=> $stable(trim_hold));

   p_load_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_load && !load_busy) |=> load_busy);

   p_match_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_match && !match_busy) |=> match_busy);

   p_match_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_match && match_busy) |=> $stable(match_hold));

   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq);

   p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt_f) |=> !irq);

   p_present_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      present |=> present);

   p_hold_off_r8: assert property (@(posedge slow_clk) disable iff (!rst_n)
      (!en_s && !load_stb) |=> $stable(cnt));
endmodule

bind lfc_timer lfc_timer_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
   .wr_trim(wr_trim), .wr_load(wr_load), .wr_match(wr_match),
   .trim_busy(trim_busy), .load_busy(load_busy), .match_busy(match_busy),
   .trim_hold(trim_hold), .match_hold(match_hold),
   .load_stb(load_stb), .en_s(en_s), .cnt(cnt),
   .clr(clr), .evt_f(evt_f), .irq(irq), .present(present));

// File: tb/lfc_timer_bench.sv
module lfc_timer_bench;
   logic        clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;
   always #100 slow_clk = ~slow_clk;

   lfc_timer u_lfc_timer (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

   typedef struct {
      string       tag;
      bit          pin;
      logic [2:0]  addr;
      logic [31:0] mask;
      logic [31:0] lo;
      logic [31:0] hi;
   } item_t;

   item_t q[$];
   bit    done = 1'b0;

   // monitor: pops expected items and compares against the design
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            rd_addr = it.addr;
            #1;
            act = it.pin ? {31'b0, irq} : (rd_data & it.mask);
            total++;
            if (act < it.lo || act > it.hi) begin
               bad++;
               $display("FAIL %s: actual=0x%08h expected=0x%08h..0x%08h", it.tag, act, it.lo, it.hi);
            end
         end
      end
   end

   task automatic expect_rng(input string tag, input bit pin, input logic [2:0] a,
                             input logic [31:0] m, input logic [31:0] lo, input logic [31:0] hi);
      item_t it;
      it.tag = tag; it.pin = pin; it.addr = a; it.mask = m; it.lo = lo; it.hi = hi;
      q.push_back(it);
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic expect_reg(input string tag, input logic [2:0] a,
                             input logic [31:0] m, input logic [31:0] v);
      expect_rng(tag, 1'b0, a, m, v, v);
   endtask

   task automatic expect_irq(input string tag, input bit v);
      expect_rng(tag, 1'b1, 3'd0, 32'h1, {31'b0, v}, {31'b0, v});
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_slow(input int n);
      repeat (n) @(posedge slow_clk);
      @(negedge clk);
   endtask

   // run enable for n slow edges from a preloaded, stopped counter
   task automatic run_for(input logic [31:0] start, input int n);
      wr(3'd1, start);
      wait_slow(12);
      wr(3'd0, 32'h1);
      wait_slow(n);
      wr(3'd0, 32'h0);
      wait_slow(12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      expect_reg("reset busy bits R3 R4 R5", 3'd0, 32'h1D, 32'h0);
      expect_reg("reset count R9", 3'd1, 32'hFFFF_FFFF, 32'h0);
      expect_reg("reset irq status R6", 3'd4, 32'h1, 32'h0);
      expect_irq("reset irq pin R6", 1'b0);

      wait_slow(4);
      expect_reg("slow clock seen R7", 3'd0, 32'h2, 32'h2);

      // preload with counter stopped
      wr(3'd1, 32'h0000_1000);
      expect_reg("count busy set R4", 3'd0, 32'h8, 32'h8);
      wait_slow(12);
      expect_reg("count busy cleared R4", 3'd0, 32'h8, 32'h0);
      expect_reg("preload read R4 R9", 3'd1, 32'hFFFF_FFFF, 32'h0000_1000);
      wait_slow(10);
      expect_reg("disabled holds R8", 3'd1, 32'hFFFF_FFFF, 32'h0000_1000);

      // trim, with a second write dropped while busy
      wr(3'd2, 32'd3);
      wr(3'd2, 32'd0);
      expect_reg("trim busy set R3", 3'd0, 32'h4, 32'h4);
      wait_slow(8);
      expect_reg("trim busy cleared R3", 3'd0, 32'h4, 32'h0);
      expect_reg("trim second write ignored R3", 3'd2, 32'hFFFF_FFFF, 32'd3);
      run_for(32'h0, 80);
      expect_rng("trim 3 rate R2 R3", 1'b0, 3'd1, 32'hFFFF_FFFF, 32'd19, 32'd21);

      wr(3'd2, 32'd0);
      wait_slow(8);
      run_for(32'h0, 40);
      expect_rng("trim 0 rate R2", 1'b0, 3'd1, 32'hFFFF_FFFF, 32'd39, 32'd41);

      // wrap through zero (compare at reset value 0 fires here)
      run_for(32'hFFFF_FFFE, 8);
      expect_rng("wrap R1", 1'b0, 3'd1, 32'hFFFF_FFFF, 32'd4, 32'd8);
      expect_irq("compare at 0 on wrap R6", 1'b1);
      wr(3'd4, 32'h1);
      expect_irq("clear irq R6", 1'b0);
      expect_reg("clear status R6", 3'd4, 32'h1, 32'h0);

      // compare scheduling, second compare write dropped
      wr(3'd1, 32'd100);
      wait_slow(12);
      wr(3'd3, 32'd110);
      wr(3'd3, 32'd300);
      expect_reg("compare busy set R5", 3'd0, 32'h10, 32'h10);
      wait_slow(8);
      expect_reg("compare busy cleared R5", 3'd0, 32'h10, 32'h0);
      expect_reg("compare second write ignored R5", 3'd3, 32'hFFFF_FFFF, 32'd110);
      wr(3'd0, 32'h1);
      wait_slow(4);
      expect_irq("no irq before compare R6", 1'b0);
      wait_slow(20);
      expect_irq("irq at compare R6", 1'b1);
      wr(3'd0, 32'h0);
      wait_slow(12);
      expect_reg("irq status sticky R6", 3'd4, 32'h1, 32'h1);
      wr(3'd4, 32'h0);
      expect_irq("write 0 keeps irq R6", 1'b1);
      wr(3'd4, 32'h1);
      expect_irq("irq cleared R6", 1'b0);
      wait_slow(10);
      expect_irq("no retrigger R6", 1'b0);

      // compare behind the count is never reached
      wr(3'd3, 32'd50);
      wait_slow(8);
      wr(3'd0, 32'h1);
      wait_slow(30);
      expect_irq("compare behind count silent R6", 1'b0);
      wr(3'd0, 32'h0);
      expect_reg("slow clock seen still set R7", 3'd0, 32'h2, 32'h2);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule